// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block is a behavioural model of a parallel NOR flash device with a command-driven write interface. It holds its storage in a small internal byte array. A host reaches it over a simple synchronous bus with an address, write data, a write strobe, a read strobe, an access size of 1, 2 or 4 bytes and a byte-order select. A write is either a command byte (the low 8 bits of the write data) or a data word, depending on where the device is within a multi-write sequence.

A two-bit sequence counter and a latched command byte decide what a read returns: array data, the status byte, identifier words, or bytes of a query table. The supported sequences are single-word program, sector erase, buffered block write with a word count, and a lock/unlock handshake. A read-only input takes the place of write protection. When it is high, program and erase set error bits in the status byte and leave the array as it was. Operation timing is not modelled: every operation completes at the write that triggers it.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: Reset clears the status byte, the latched command and the sequence counter, so the device starts in read-array mode; rdata resets to 0.
- R2: In sequence step 0, command 0x00, 0xF0 or 0xFF returns to read-array mode. Command 0x50 clears all status bits and also returns to read-array mode.
- R3: Commands 0x70 and 0x90 latch the command but keep the sequence step at 0. While the latched command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, a read returns the status byte, zero-extended.
- R4: After 0x10 or 0x40, the next write stores its data at the written address, sets status bit 7 (ready) and returns to step 0. Size codes are 0 = 1 byte, 1 = 2 bytes and 2 = 4 bytes. With big_end = 1 the most significant byte goes to the lowest address; with big_end = 0 the least significant byte does. Reads use the same encoding.
- R5: A single-word program while read_only is high stores nothing and sets status bits 4 and 7.
- R6: Command 0x20 at once fills the SECTOR_BYTES-aligned sector that holds the address with 0xFF and sets status bit 7. When read_only is high it erases nothing and sets bits 5 and 7.
- R7: In the second write of an erase, 0xD0 sets bit 7 and returns to step 0 with 0x20 still latched. Any other value, 0xFF included, returns to read-array mode.
- R8: After 0x60, a second write of 0xD0 or 0x01 sets bit 7 and returns to step 0 with 0x60 still latched. Any other value returns to read-array mode.
- R9: Command 0xE8 sets bit 7 at once. The next write loads a word count N (its width is 8 bits for a 1-byte device and 11 bits for wider ones). The following N+1 writes each store one data word, and then a write of 0xD0 confirms and sets bit 7.
- R10: In the confirm step of a buffered write, any value other than 0xD0 returns to read-array mode, keeps the stored words and leaves the status byte unchanged.
- R11: After 0x90, a read uses index (addr[7:0] >> log2(DEV_WIDTH)). Index 0 returns {ID0, ID1}, index 1 returns {ID2, ID3}, and any other index returns 0.
- R12: After 0x98, a read returns the query byte at that index: 0x10 to 0x12 hold "QRY" (0x51, 0x52, 0x59), and 0x2A holds 0x08 for a 1-byte device or 0x0B for a wider one. An index past 0x52 reads 0. The device stays in query mode until 0xFF is written.
- R13: An unknown command in step 0, or an illegal command/step pairing, returns to read-array mode with the status byte unchanged. Status bits are sticky: they are only cleared by 0x50 or by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data; bits 7:0 carry commands |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| size | input | 2 | Access size: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes |
| big_end | input | 1 | 1 selects big-endian byte order |
| read_only | input | 1 | Blocks program and erase and flags an error instead |
| rdata | output | 32 | Read data, registered |

## Verification
A write takes effect at the rising edge where wr_en is sampled. The array, the status byte and the mode therefore all hold their new values by the next cycle. Read data is registered: rdata shows the value for the addressed location in the cycle after the edge that samples rd_en, and it holds that value until the next read. The bench drives every strobe for one cycle from the falling edge and samples rdata at the following falling edge, which is exactly one register stage after the read. It never reads in the same cycle as a write.

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int DEPTH        = 256,
  parameter int SECTOR_BYTES = 64,
  parameter int DEV_WIDTH    = 2,
  parameter logic [7:0] ID0  = 8'h89,
  parameter logic [7:0] ID1  = 8'h18,
  parameter logic [7:0] ID2  = 8'h00,
  parameter logic [7:0] ID3  = 8'h17,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [1:0]    size,
  input  logic          big_end,
  input  logic          read_only,
  output logic [31:0]   rdata
);
  localparam int BUF_LOG = (DEV_WIDTH == 1) ? 8 : 11;
  localparam int CW      = BUF_LOG;
  localparam int WSH     = (DEV_WIDTH == 4) ? 2 : (DEV_WIDTH == 2) ? 1 : 0;
  localparam int NSECT   = DEPTH / SECTOR_BYTES;
  localparam logic [7:0] QLEN = 8'h52;
  localparam logic [AW-1:0] SMASK = ~AW'(SECTOR_BYTES - 1);

  logic [7:0]    mem [DEPTH];
  logic [1:0]    cyc;
  logic [7:0]    cmd;
  logic [7:0]    status;
  logic [CW-1:0] cnt;
  logic [31:0]   rd_val;

  wire [7:0] wbyte  = wdata[7:0];
  wire [7:0] boff   = addr[7:0] >> WSH;
  wire       is_prg = (cmd == 8'h10) || (cmd == 8'h40);
  wire [7:0] ok_set = read_only ? 8'h90 : 8'h80;
  wire erase_en = wr_en && !read_only && (cyc == 2'd0) && (wbyte == 8'h20);
  wire prog_en  = wr_en && !read_only &&
                  (((cyc == 2'd1) && is_prg) || ((cyc == 2'd2) && (cmd == 8'hE8)));

  function automatic int nbytes(input logic [1:0] s);
    return (s == 2'd0) ? 1 : (s == 2'd1) ? 2 : 4;
  endfunction

  function automatic logic [7:0] qbyte(input logic [7:0] i);
    if (i > QLEN) return 8'h00;
    case (i)
      8'h10: return 8'h51;
      8'h11: return 8'h52;
      8'h12: return 8'h59;
      8'h13: return 8'h01;
      8'h15: return 8'h31;
      8'h27: return 8'($clog2(DEPTH));
      8'h28: return 8'h02;
      8'h2A: return 8'(BUF_LOG);
      8'h2C: return 8'h01;
      8'h2D: return 8'(NSECT - 1);
      8'h2F: return 8'(SECTOR_BYTES >> 8);
      8'h30: return 8'(SECTOR_BYTES >> 16);
      default: return 8'h00;
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (erase_en)
      for (int j = 0; j < DEPTH; j++)
        if ((AW'(j) & SMASK) == (addr & SMASK)) mem[j] <= 8'hFF;
    if (prog_en)
      for (int k = 0; k < 4; k++)
        if (k < nbytes(size))
          mem[addr + AW'(k)] <= wdata[8*(big_end ? nbytes(size)-1-k : k) +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc <= 2'd0; cmd <= 8'h00; status <= 8'h00; cnt <= '0;
    end else if (wr_en) begin
      case (cyc)
        2'd0: case (wbyte)
          8'h50: begin status <= 8'h00; cmd <= 8'h00; end
          8'h70, 8'h90: cmd <= wbyte;
          8'h10, 8'h40, 8'h60, 8'h98: begin cmd <= wbyte; cyc <= 2'd1; end
          8'h20: begin
            cmd <= wbyte; cyc <= 2'd1;
            status <= status | (read_only ? 8'hA0 : 8'h80);
          end
          8'hE8: begin cmd <= wbyte; cyc <= 2'd1; status <= status | 8'h80; end
          default: begin cmd <= 8'h00; cyc <= 2'd0; end
        endcase
        2'd1: case (cmd)
          8'h10, 8'h40: begin status <= status | ok_set; cyc <= 2'd0; end
          8'h20, 8'h28, 8'h60:
            if (wbyte == 8'hD0 || (cmd == 8'h60 && wbyte == 8'h01)) begin
              status <= status | 8'h80; cyc <= 2'd0;
            end else begin
              cmd <= 8'h00; cyc <= 2'd0;
            end
          8'h98: if (wbyte == 8'hFF) begin cmd <= 8'h00; cyc <= 2'd0; end
          8'hE8: begin cnt <= wdata[CW-1:0]; cyc <= 2'd2; end
          default: begin cmd <= 8'h00; cyc <= 2'd0; end
        endcase
        2'd2:
          if (cmd == 8'hE8) begin
            status <= status | ok_set;
            if (cnt == '0) cyc <= 2'd3;
            cnt <= cnt - 1'b1;
          end else begin
            cmd <= 8'h00; cyc <= 2'd0;
          end
        default:
          if (cmd == 8'hE8 && wbyte == 8'hD0) begin
            status <= status | 8'h80; cyc <= 2'd0;
          end else begin
            cmd <= 8'h00; cyc <= 2'd0;
          end
      endcase
    end
  end

  always_comb begin
    logic [7:0] b0, b1, b2, b3;
    b0 = mem[addr];
    b1 = mem[addr + AW'(1)];
    b2 = mem[addr + AW'(2)];
    b3 = mem[addr + AW'(3)];
    case (cmd)
      8'h90: rd_val = (boff == 8'd0) ? {16'h0, ID0, ID1} :
                      (boff == 8'd1) ? {16'h0, ID2, ID3} : 32'h0;
      8'h98: rd_val = {24'h0, qbyte(boff)};
      8'h10, 8'h20, 8'h28, 8'h40, 8'h50, 8'h60, 8'h70, 8'hE8:
        rd_val = {24'h0, status};
      default:
        case (size)
          2'd0:    rd_val = {24'h0, b0};
          2'd1:    rd_val = big_end ? {16'h0, b0, b1} : {16'h0, b1, b0};
          default: rd_val = big_end ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
        endcase
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rdata <= 32'h0;
    else if (rd_en) rdata <= rd_val;
endmodule

// File: rtl/flash_cmd_ctrl_chk.sv
module flash_cmd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wbyte,
  input logic [1:0] cyc,
  input logic [7:0] cmd,
  input logic [7:0] status,
  input logic       cnt_zero
);
  wire step0 = wr_en && (cyc == 2'd0);

  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    step0 && wbyte == 8'h50 |=> status == 8'h00); // R2
  AST_BACK_TO_ARRAY: assert property (@(posedge clk) disable iff (!rst_n)
    step0 && (wbyte == 8'h00 || wbyte == 8'hF0 || wbyte == 8'hFF) |=> cyc == 2'd0 && cmd == 8'h00); // R2
  AST_LATCH_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    step0 && (wbyte == 8'h70 || wbyte == 8'h90) |=> cyc == 2'd0 && cmd == $past(wbyte)); // R3
  AST_ERASE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    step0 && wbyte == 8'h20 |=> status[7] && cyc == 2'd1); // R6
  AST_BUF_TO_CONFIRM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && cyc == 2'd2 && cmd == 8'hE8 && cnt_zero |=> cyc == 2'd3); // R9
  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !(step0 && wbyte == 8'h50) |=> (status & $past(status)) == $past(status)); // R13
  AST_UNKNOWN_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    step0 && !(wbyte inside {8'h00, 8'h10, 8'h20, 8'h40, 8'h50, 8'h60, 8'h70, 8'h90, 8'h98, 8'hE8, 8'hF0, 8'hFF})
    |=> cyc == 2'd0 && cmd == 8'h00 && status == $past(status)); // R13
endmodule

bind flash_cmd_ctrl flash_cmd_ctrl_chk chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wbyte(wdata[7:0]),
  .cyc(cyc), .cmd(cmd), .status(status), .cnt_zero(cnt == '0)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0;
  logic        wr_en = 0, rd_en = 0, big_end = 0, read_only = 0;
  logic [1:0]  size = 0;
  logic [31:0] rdata;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  flash_cmd_ctrl uut (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .size(size), .big_end(big_end),
    .read_only(read_only), .rdata(rdata));

  always #5 clk = ~clk;

  // {op, size, big_end, addr, data}; op 0 = write, 1 = read and compare with data
  localparam int NV = 29;
  localparam logic [51:0] VEC [NV] = '{
    52'h0_0_0_00_00000040,  // R4 program
    52'h0_1_0_10_0000A5B6,
    52'h0_0_0_00_000000FF,
    52'h1_1_0_10_0000A5B6,  // R4 little-endian half
    52'h1_1_1_10_0000B6A5,  // R4 big-endian half
    52'h1_0_0_10_000000B6,
    52'h0_0_0_00_00000040,
    52'h0_2_1_20_11223344,  // R4 big-endian word
    52'h0_0_0_00_000000FF,
    52'h1_2_0_20_44332211,
    52'h1_0_0_22_00000033,
    52'h0_0_0_00_00000070,  // R3
    52'h1_0_0_00_00000080,
    52'h0_0_0_00_00000050,  // R2
    52'h0_0_0_00_00000070,
    52'h1_0_0_00_00000000,
    52'h0_0_0_00_00000090,  // R11
    52'h1_1_0_00_00008918,
    52'h1_1_0_02_00000017,
    52'h1_1_0_04_00000000,
    52'h0_0_0_00_00000098,  // R12
    52'h1_0_0_20_00000051,
    52'h1_0_0_54_0000000B,
    52'h0_0_0_00_00000000,
    52'h1_0_0_22_00000052,
    52'h1_0_0_FE_00000000,
    52'h0_0_0_00_000000FF,
    52'h1_2_0_20_44332211,
    52'h1_0_0_10_000000B6
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d,
                    input logic [1:0] s = 2'd0, input logic b = 1'b0);
    addr = a; wdata = d; size = s; big_end = b; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rdc(input string tag, input logic [7:0] a, input logic [1:0] s,
                     input logic b, input logic [31:0] exp);
    addr = a; size = s; big_end = b; rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    chk(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 rdata after reset", rdata, 32'h0);
    rst_n = 1;
    @(negedge clk);
    wr(8'h00, 32'h70);
    rdc("R1 status after reset", 8'h00, 2'd0, 1'b0, 32'h0);
    wr(8'h00, 32'hFF);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][51:48] == 4'd0)
        wr(VEC[i][39:32], VEC[i][31:0], VEC[i][45:44], VEC[i][40]);
      else
        rdc($sformatf("table[%0d]", i), VEC[i][39:32], VEC[i][45:44], VEC[i][40], VEC[i][31:0]);
    end

    // R6 / R7 erase of sector 0x40..0x7F
    wr(8'h00, 32'h40); wr(8'h46, 32'h1234, 2'd1);
    wr(8'h47, 32'h20); wr(8'h47, 32'hD0);
    wr(8'h00, 32'h70);
    rdc("R6 erase ready status", 8'h00, 2'd0, 1'b0, 32'h80);
    wr(8'h00, 32'hFF);
    rdc("R6 sector start erased", 8'h40, 2'd2, 1'b0, 32'hFFFFFFFF);
    rdc("R6 sector end erased", 8'h7C, 2'd2, 1'b0, 32'hFFFFFFFF);
    rdc("R6 programmed word erased", 8'h46, 2'd1, 1'b0, 32'h0000FFFF);
    rdc("R6 other sector kept", 8'h20, 2'd2, 1'b0, 32'h44332211);
    wr(8'h80, 32'h20); wr(8'h80, 32'h33);
    rdc("R7 bad erase confirm -> array", 8'h80, 2'd1, 1'b0, 32'h0000FFFF);

    // R9 buffered write of N+1 = 3 words
    wr(8'h00, 32'h50);
    wr(8'h80, 32'hE8);
    rdc("R9 ready after buffer command", 8'h00, 2'd0, 1'b0, 32'h80);
    wr(8'h80, 32'h2);
    wr(8'h80, 32'h1111, 2'd1); wr(8'h82, 32'h2222, 2'd1); wr(8'h84, 32'h3333, 2'd1);
    wr(8'h86, 32'hD0, 2'd1);
    wr(8'h00, 32'h70);
    rdc("R9 status after confirm", 8'h00, 2'd0, 1'b0, 32'h80);
    wr(8'h00, 32'hFF);
    rdc("R9 first word", 8'h80, 2'd1, 1'b0, 32'h1111);
    rdc("R9 last word", 8'h84, 2'd1, 1'b0, 32'h3333);
    rdc("R9 confirm not stored", 8'h86, 2'd1, 1'b0, 32'hFFFF);

    // R10 wrong confirm value
    wr(8'h88, 32'hE8); wr(8'h88, 32'h0); wr(8'h88, 32'h5555, 2'd1); wr(8'h88, 32'h77);
    rdc("R10 bad confirm -> array", 8'h88, 2'd1, 1'b0, 32'h5555);
    wr(8'h00, 32'h70);
    rdc("R10 status unchanged", 8'h00, 2'd0, 1'b0, 32'h80);

    // R8 lock handshake
    wr(8'h00, 32'h50);
    wr(8'h00, 32'h60); wr(8'h00, 32'h01);
    rdc("R8 lock with 0x01", 8'h00, 2'd0, 1'b0, 32'h80);
    wr(8'h00, 32'h50);
    wr(8'h00, 32'h60); wr(8'h00, 32'hD0);
    rdc("R8 unlock with 0xD0", 8'h00, 2'd0, 1'b0, 32'h80);
    wr(8'h00, 32'h60); wr(8'h00, 32'h42);
    rdc("R8 bad second write -> array", 8'h88, 2'd1, 1'b0, 32'h5555);

    // R13 unknown command
    wr(8'h00, 32'h33);
    rdc("R13 unknown command -> array", 8'h88, 2'd1, 1'b0, 32'h5555);
    wr(8'h00, 32'h70);
    rdc("R13 status unchanged", 8'h00, 2'd0, 1'b0, 32'h80);

    // R5 / R6 read-only
    wr(8'h00, 32'h50);
    read_only = 1;
    wr(8'h00, 32'h40); wr(8'h88, 32'hBEEF, 2'd1);
    wr(8'h00, 32'h70);
    rdc("R5 read-only program status", 8'h00, 2'd0, 1'b0, 32'h90);
    wr(8'h00, 32'hFF);
    rdc("R5 read-only program ignored", 8'h88, 2'd1, 1'b0, 32'h5555);
    wr(8'h00, 32'h50);
    wr(8'h88, 32'h20); wr(8'h88, 32'hD0);
    wr(8'h00, 32'h70);
    rdc("R6 read-only erase status", 8'h00, 2'd0, 1'b0, 32'hA0);
    wr(8'h00, 32'hFF);
    rdc("R6 read-only erase ignored", 8'h88, 2'd1, 1'b0, 32'h5555);
    read_only = 0;

    // R13 sticky status across other commands
    wr(8'h00, 32'h98); wr(8'h00, 32'hFF); wr(8'h00, 32'h70);
    rdc("R13 status sticky", 8'h00, 2'd0, 1'b0, 32'hA0);

    // R1 reset in mid sequence
    wr(8'h00, 32'hE8);
    rst_n = 0; @(negedge clk); rst_n = 1; @(negedge clk);
    chk("R1 rdata cleared by reset", rdata, 32'h0);
    wr(8'h00, 32'h70);
    rdc("R1 status cleared by reset", 8'h00, 2'd0, 1'b0, 32'h0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule